// File: doc/BRIEF.md
# Odd/Even 50% Duty Output Divider

This block divides a fast input clock by 3, 4, 5 or 6 and keeps the high time at exactly half the output period for every ratio. The odd ratios need half an input cycle of resolution, so one waveform is built on rising input edges and a copy of it is taken half a cycle later on falling edges. The two are then combined. The even ratios use the delayed copy alone, so every output rising edge falls on a falling input edge whatever the ratio.

The ratio code comes from a configuration register outside the block. A new code waits until the period in progress has finished, so no pulse is cut short. The divided clock goes to a set of outputs that all carry the same waveform. Each output has its own enable and floats when disabled. An active-low asynchronous reset clears the divider and holds every enabled output low. On release, division restarts at once.

Top module: `duty50_div`

## Requirements
- R1: The output period is N input clock cycles, where sel_i = 00 gives N=3, 01 gives N=4, 10 gives N=5 and 11 gives N=6.
- R2: For every ratio, the output is high for exactly N input half-cycles, which is half the output period.
- R3: When enabled, every output carries the same divided clock with the same phase.
- R4: oe_i[k] high drives q_o[k] with the divided clock. oe_i[k] low puts q_o[k] in high impedance and leaves the other outputs unaffected.
- R5: While rst_ni is low, every enabled output is low at once, with no clock edge needed, and the divider state is cleared.
- R6: After rst_ni is released, the first output rising edge comes within one output period of the new ratio.
- R7: A change of sel_i takes effect at the next output period boundary. The period in progress completes with the old ratio, and the next period uses the new one.
- R8: Every output rising edge coincides with a falling edge of clk_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| sel_i | input | SEL_W (2) | Ratio code, N = DIV_MIN + sel_i |
| oe_i | input | NUM_OUT (2) | Per-output enable, high drives |
| q_o | output | NUM_OUT (2) | Divided clock outputs, high impedance when disabled |

## Verification
On every cycle, the assertions check four things. The phase counter restarts at a period boundary. The latched ratio never moves in the middle of a period and always stays inside the legal range. The divided clock is low at every boundary, where the odd and even paths may swap. The exact high time and period in half-cycles cannot be seen from one cycle, so only the bench's edge-timing scenarios show them. The same holds for the first edge after reset, the deferred ratio change, the asynchronous reset and the per-output high impedance.

// File: rtl/duty50_div_pkg.sv
package duty50_div_pkg;
  // rising-edge cycles the lead waveform stays high for a ratio n
  function automatic int unsigned lead_len(int unsigned n);
    return (n + 1) / 2;
  endfunction
endpackage

// File: rtl/duty50_div_count.sv
module duty50_div_count #(
  parameter int SEL_W   = 2,
  parameter int DIV_MIN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             lead_o,
  output logic             odd_o,
  output logic             wrap_o
);
  localparam int DIV_MAX = DIV_MIN + (2 ** SEL_W) - 1;
  localparam int CNT_W   = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, n_q, n_d;
  logic             lead_q, lead_d, wrap;

  assign wrap = (cnt_q >= (n_q - 1'b1));

  always_comb begin
    if (wrap) begin
      cnt_d = '0;
      n_d   = CNT_W'(DIV_MIN) + CNT_W'(sel_i);
    end else begin
      cnt_d = cnt_q + 1'b1;
      n_d   = n_q;
    end
    lead_d = (32'(cnt_d) < duty50_div_pkg::lead_len(32'(n_d)));
  end

  // all-ones count forces a wrap on the first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      n_q    <= CNT_W'(DIV_MIN);
      lead_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      n_q    <= n_d;
      lead_q <= lead_d;
    end
  end

  assign lead_o = lead_q;
  assign odd_o  = n_q[0];
  assign wrap_o = wrap;

  p_wrap_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (cnt_q == '0));
  p_ratio_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(n_q));
  p_ratio_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(n_q) >= DIV_MIN) && (32'(n_q) <= DIV_MAX));
endmodule

// File: rtl/duty50_div_phase.sv
module duty50_div_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lead_i,
  input  logic odd_i,
  input  logic wrap_i,
  output logic clk_o
);
  logic lag_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lag_q <= 1'b0;
    else         lag_q <= lead_i;
  end

  // odd: overlap of lead and lag gives N half-cycles; even: lag alone
  assign clk_o = odd_i ? (lead_i & lag_q) : lag_q;

  // both paths are low at the boundary where the mux select may change
  p_boundary_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |-> !clk_o);
endmodule

// File: rtl/duty50_div_outbuf.sv
module duty50_div_outbuf #(
  parameter int NUM_OUT = 2
) (
  input  logic               clk_i,
  input  logic [NUM_OUT-1:0] oe_i,
  output logic [NUM_OUT-1:0] q_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign q_o[g] = oe_i[g] ? clk_i : 1'bz;
  end
endmodule

// File: rtl/duty50_div.sv
module duty50_div #(
  parameter int SEL_W   = 2,
  parameter int DIV_MIN = 3,
  parameter int NUM_OUT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_OUT-1:0] oe_i,
  output logic [NUM_OUT-1:0] q_o
);
  logic lead, odd, wrap, div_clk;

  duty50_div_count #(.SEL_W(SEL_W), .DIV_MIN(DIV_MIN)) u_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel_i),
    .lead_o(lead),
    .odd_o (odd),
    .wrap_o(wrap)
  );

  duty50_div_phase u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lead_i(lead),
    .odd_i (odd),
    .wrap_i(wrap),
    .clk_o (div_clk)
  );

  duty50_div_outbuf #(.NUM_OUT(NUM_OUT)) u_outbuf (
    .clk_i(div_clk),
    .oe_i (oe_i),
    .q_o  (q_o)
  );
endmodule

// File: tb/duty50_div_bench.sv
`timescale 1ns/1ps
module duty50_div_bench;
  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] per_h;
    logic [7:0] hi_h;
  } vec_t;

  // ratio code, expected period and high time in input half-cycles
  localparam vec_t VEC [8] = '{
    '{2'd0, 8'd6,  8'd3}, '{2'd1, 8'd8,  8'd4},
    '{2'd2, 8'd10, 8'd5}, '{2'd3, 8'd12, 8'd6},
    '{2'd2, 8'd10, 8'd5}, '{2'd0, 8'd6,  8'd3},
    '{2'd3, 8'd12, 8'd6}, '{2'd1, 8'd8,  8'd4}
  };

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [1:0] sel;
  logic [1:0] oe;
  wire  [1:0] q;
  logic       msel = 1'b0;
  logic       mon;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;
  realtime    t0, t1, t2, t3, t4;
  int         eq_mid;

  always #2 clk = ~clk;
  assign mon = msel ? q[1] : q[0];

  duty50_div u_duty50_div (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .sel_i (sel),
    .oe_i  (oe),
    .q_o   (q)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int halves(input realtime d);
    return int'(d / 2.0);
  endfunction

  // one rise-fall-rise window on the monitored output
  task automatic measure(output int per_h, output int hi_h, output int eq);
    @(posedge mon); t0 = $realtime;
    #1 eq = (q[1] === q[0]) ? 1 : 0;
    @(negedge mon); t1 = $realtime;
    @(posedge mon); t2 = $realtime;
    per_h = halves(t2 - t0);
    hi_h  = halves(t1 - t0);
  endtask

  initial begin
    int p, h, e;
    rst_ni = 1'b1; sel = 2'd1; oe = 2'b11;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(q[0] === 1'b0, "R5 reset q0", int'(q[0]), 0);
    check(q[1] === 1'b0, "R5 reset q1", int'(q[1]), 0);

    // release and time the first rising edge (N=4 -> within 16 ns)
    @(posedge clk); #1 rst_ni = 1'b1; t0 = $realtime;
    @(posedge mon); t1 = $realtime;
    check((t1 - t0) <= 16.0, "R6 first edge ns", int'(t1 - t0), 16);
    check(clk === 1'b0, "R8 rise on falling clk", int'(clk), 0);

    foreach (VEC[i]) begin
      sel = VEC[i].sel;
      repeat (2) @(posedge mon);
      measure(p, h, e);
      check(p == int'(VEC[i].per_h), "R1 period", p, int'(VEC[i].per_h));
      check(h == int'(VEC[i].hi_h), "R2 high time", h, int'(VEC[i].hi_h));
      check(e == 1, "R3 outputs equal", e, 1);
      check(clk === 1'b0, "R8 rise on falling clk", int'(clk), 0);
    end

    // R4: disable q0, q1 keeps dividing (sel=1 -> 8 half-cycles)
    msel = 1'b1; oe = 2'b10;
    #1 check(q[0] === 1'bz, "R4 q0 high-z", (q[0] === 1'bz) ? 1 : 0, 1);
    measure(p, h, e);
    check(p == 8, "R4 q1 period with q0 off", p, 8);
    check(q[0] === 1'bz, "R4 q0 stays high-z", (q[0] === 1'bz) ? 1 : 0, 1);
    msel = 1'b0; oe = 2'b01;
    #1 check(q[1] === 1'bz, "R4 q1 high-z", (q[1] === 1'bz) ? 1 : 0, 1);
    measure(p, h, e);
    check(p == 8, "R4 q0 period with q1 off", p, 8);
    oe = 2'b11;

    // R7: switch 6 -> 3 right after a rise
    sel = 2'd3;
    repeat (2) @(posedge mon);
    @(posedge mon); t0 = $realtime;
    #1 sel = 2'd0;
    @(negedge mon); t1 = $realtime;
    @(posedge mon); t2 = $realtime;
    @(negedge mon); t3 = $realtime;
    @(posedge mon); t4 = $realtime;
    check(halves(t1 - t0) == 6, "R7 old high kept", halves(t1 - t0), 6);
    check(halves(t2 - t0) == 12, "R7 old period kept", halves(t2 - t0), 12);
    check(halves(t3 - t2) == 3, "R7 new high", halves(t3 - t2), 3);
    check(halves(t4 - t2) == 6, "R7 new period", halves(t4 - t2), 6);

    // R5: reset while output high drops it without a clock edge
    @(posedge mon); #0.5;
    rst_ni = 1'b0;
    #0.2;
    check(q[0] === 1'b0, "R5 async low q0", int'(q[0]), 0);
    check(q[1] === 1'b0, "R5 async low q1", int'(q[1]), 0);
    repeat (4) @(posedge clk);
    #1 check(q[0] === 1'b0, "R5 held low", int'(q[0]), 0);
    sel = 2'd2;
    @(posedge clk); #1 rst_ni = 1'b1; t0 = $realtime;
    @(posedge mon); t1 = $realtime;
    check((t1 - t0) <= 20.0, "R6 first edge after re-reset ns", int'(t1 - t0), 20);
    measure(p, h, e);
    check(p == 10, "R6 period after restart", p, 10);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule